// File: doc/BRIEF.md
# Bit Counting and Parity Unit

This unit takes one 64-bit operand and an operation code and returns one 64-bit result. The operations are leading-zero and trailing-zero counts over the low word or the whole doubleword, population counts packed per byte lane, per 32-bit half or over the whole operand, and parity of the byte least significant bits per 32-bit half or over the whole operand. Count results are zero-extended to 64 bits. An operand with no set bit in the scanned range gives the full width of that range.

Bit numbering is LSB-0: bit 0 is the least significant bit. The word forms of the zero counts look only at bits 31..0. The leading count starts at bit 31 and the trailing count starts at bit 0.

The datapath is one combinational stage followed by a result register. A two-state controller tracks whether the register holds a fresh result:
- ST_IDLE: no result is presented.
- ST_VALID: a result is presented.

The controller has these transitions:
- ACCEPT: ST_IDLE to ST_VALID when `in_valid` is high.
- STREAM: ST_VALID to ST_VALID when `in_valid` is high again.
- DRAIN: ST_VALID to ST_IDLE when `in_valid` is low.
- WAIT: ST_IDLE to ST_IDLE when `in_valid` is low.

Top module: `bitcount_unit`

## Requirements
- R1: An input accepted with `in_valid` high at a clock edge appears on `result` with `out_valid` high after exactly that edge. `out_valid` is low in the cycle after an edge where `in_valid` was low. Reset clears `out_valid` and `result` to zero.
- R2: Op code 0 (word leading zeros) counts zero bits from bit 31 downward to the first set bit within bits 31..0. Bits 63..32 are ignored. The result ranges from 0 to 32.
- R3: Op code 1 (doubleword leading zeros) counts zero bits from bit 63 downward. The result ranges from 0 to 64.
- R4: Op code 2 (word trailing zeros) counts zero bits from bit 0 upward within bits 31..0. Bits 63..32 are ignored. The result ranges from 0 to 32.
- R5: Op code 3 (doubleword trailing zeros) counts zero bits from bit 0 upward. The result ranges from 0 to 64.
- R6: Op code 4 (byte population) places the number of set bits of byte k (bits 8k+7..8k) in the same byte lane of the result.
- R7: Op code 5 (half population) places the set-bit count of bits 31..0 in result bits 31..0, and the set-bit count of bits 63..32 in result bits 63..32.
- R8: Op code 6 (doubleword population) returns the total number of set bits, zero-extended.
- R9: Op code 7 (half parity) sets result bit 0 to the XOR of operand bits 0, 8, 16 and 24. It sets result bit 32 to the XOR of operand bits 32, 40, 48 and 56. All other result bits are zero.
- R10: Op code 8 (doubleword parity) sets result bit 0 to the XOR of operand bits 0, 8, 16, 24, 32, 40, 48 and 56. All other result bits are zero.
- R11: Op codes 9 to 15 give an all-zero result, still marked valid.
- R12: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and op code are valid this cycle |
| op | input | 4 | Operation code (0 to 8 defined) |
| operand | input | 64 | Source operand |
| out_valid | output | 1 | Result holds a fresh value |
| result | output | 64 | Registered result |

## Verification
The bench drives each operation with several operand patterns, and each pattern separates a different kind of fault:
- All-zero operands check that each count saturates at the width of its own range.
- All-ones operands check the zero end of each count.
- Single set bits at bit 0, bit 31, bit 32 and bit 63 catch scan-direction and word-boundary mistakes.
- Operands with bits set only in the upper half check that the word forms ignore that half.
- Mixed byte patterns with distinct per-lane counts, and parity patterns with bits set off the byte LSBs, expose lane swaps and bits that should not contribute.
- Back-to-back issue and idle gaps check the valid timing and the hold of the result register.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    typedef enum logic [3:0] {
        OP_LZ_WORD  = 4'd0,
        OP_LZ_DWORD = 4'd1,
        OP_TZ_WORD  = 4'd2,
        OP_TZ_DWORD = 4'd3,
        OP_POP_BYTE = 4'd4,
        OP_POP_HALF = 4'd5,
        OP_POP_FULL = 4'd6,
        OP_PAR_HALF = 4'd7,
        OP_PAR_FULL = 4'd8
    } bcp_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } bcp_state_e;

endpackage

// File: rtl/bcp_lead_zero.sv
// Counts zero bits from the top of vec down to the first set bit.
module bcp_lead_zero #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic seen;

    always_comb begin
        cnt  = '0;
        seen = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (vec[i]) begin
                    seen = 1'b1;
                end else begin
                    cnt = cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bcp_lane_pop.sv
// Set-bit count per lane, each count written zero-extended into its lane.
module bcp_lane_pop #(
    parameter int W    = 64,
    parameter int LANE = 8,
    localparam int NL  = W / LANE,
    localparam int CW  = $clog2(LANE + 1)
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] counts
);
    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [CW-1:0] sum;
        always_comb begin
            sum = '0;
            for (int j = 0; j < LANE; j++) begin
                sum = sum + CW'(vec[l*LANE + j]);
            end
        end
        assign counts[l*LANE +: LANE] = LANE'(sum);
    end
endmodule

// File: rtl/bcp_lane_parity.sv
// XOR of the least significant bit of every byte in a lane, put in lane bit 0.
module bcp_lane_parity #(
    parameter int W      = 64,
    parameter int LANE   = 32,
    parameter int BYTE_W = 8,
    localparam int NL    = W / LANE,
    localparam int NB    = LANE / BYTE_W
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] par
);
    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic p;
        always_comb begin
            p = 1'b0;
            for (int b = 0; b < NB; b++) begin
                p = p ^ vec[l*LANE + b*BYTE_W];
            end
        end
        assign par[l*LANE +: LANE] = {{(LANE-1){1'b0}}, p};
    end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
    import bcp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int CW_D  = $clog2(DATA_W + 1),
    localparam int CW_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    bcp_state_e        state_q, state_d;
    logic [DATA_W-1:0] result_d;
    logic [DATA_W-1:0] rev;
    logic [CW_W-1:0]   lz_word, tz_word;
    logic [CW_D-1:0]   lz_dword, tz_dword;
    logic [DATA_W-1:0] pop_byte, pop_half, pop_full;
    logic [DATA_W-1:0] par_half, par_full;

    // Bit reversal turns a trailing count into a leading count.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev[i] = operand[DATA_W-1-i];
    end

    bcp_lead_zero #(.W(WORD_W)) u_lz_word (.vec(operand[WORD_W-1:0]), .cnt(lz_word));
    bcp_lead_zero #(.W(DATA_W)) u_lz_dword (.vec(operand), .cnt(lz_dword));
    bcp_lead_zero #(.W(WORD_W)) u_tz_word (.vec(rev[DATA_W-1 -: WORD_W]), .cnt(tz_word));
    bcp_lead_zero #(.W(DATA_W)) u_tz_dword (.vec(rev), .cnt(tz_dword));

    bcp_lane_pop #(.W(DATA_W), .LANE(BYTE_W)) u_pop_byte (.vec(operand), .counts(pop_byte));
    bcp_lane_pop #(.W(DATA_W), .LANE(WORD_W)) u_pop_half (.vec(operand), .counts(pop_half));
    bcp_lane_pop #(.W(DATA_W), .LANE(DATA_W)) u_pop_full (.vec(operand), .counts(pop_full));

    bcp_lane_parity #(.W(DATA_W), .LANE(WORD_W), .BYTE_W(BYTE_W)) u_par_half (
        .vec(operand), .par(par_half));
    bcp_lane_parity #(.W(DATA_W), .LANE(DATA_W), .BYTE_W(BYTE_W)) u_par_full (
        .vec(operand), .par(par_full));

    // Operation select
    always_comb begin
        unique case (op)
            OP_LZ_WORD:  result_d = DATA_W'(lz_word);
            OP_LZ_DWORD: result_d = DATA_W'(lz_dword);
            OP_TZ_WORD:  result_d = DATA_W'(tz_word);
            OP_TZ_DWORD: result_d = DATA_W'(tz_dword);
            OP_POP_BYTE: result_d = pop_byte;
            OP_POP_HALF: result_d = pop_half;
            OP_POP_FULL: result_d = pop_full;
            OP_PAR_HALF: result_d = par_half;
            OP_PAR_FULL: result_d = par_full;
            default:     result_d = '0;
        endcase
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;   // ACCEPT / WAIT
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;   // STREAM / DRAIN
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= result_d;
        end
    end

    assign out_valid = (state_q == ST_VALID);

    // Assertions
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    p_lzw_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LZ_WORD && operand[WORD_W-1:0] == '0)
        |=> result == DATA_W'(WORD_W));
    p_lzd_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LZ_DWORD && operand == '0) |=> result == DATA_W'(DATA_W));
    p_tzd_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_TZ_DWORD && operand[0]) |=> result == '0);
    p_par_half_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_PAR_HALF)
        |=> (result & ~((DATA_W'(1) << WORD_W) | DATA_W'(1))) == '0);
    p_par_full_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_PAR_FULL) |=> result[DATA_W-1:1] == '0);
    p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd8) |=> result == '0);
endmodule

// File: tb/sim_bitcount_unit.sv
`timescale 1ns/1ps
module sim_bitcount_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [63:0] operand = 64'd0;
    logic        out_valid;
    logic [63:0] result;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    bitcount_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .operand(operand), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference model
    function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] v);
        logic [63:0] r = '0;
        int n = 0;
        case (o)
            4'd0: begin while (n < 32 && !v[31-n]) n++; r = 64'(n); end
            4'd1: begin while (n < 64 && !v[63-n]) n++; r = 64'(n); end
            4'd2: begin while (n < 32 && !v[n]) n++; r = 64'(n); end
            4'd3: begin while (n < 64 && !v[n]) n++; r = 64'(n); end
            4'd4: for (int k = 0; k < 8; k++) r[8*k +: 8] = 8'($countones(v[8*k +: 8]));
            4'd5: begin
                r[31:0]  = 32'($countones(v[31:0]));
                r[63:32] = 32'($countones(v[63:32]));
            end
            4'd6: r = 64'($countones(v));
            4'd7: begin
                r[0]  = v[0] ^ v[8] ^ v[16] ^ v[24];
                r[32] = v[32] ^ v[40] ^ v[48] ^ v[56];
            end
            4'd8: r[0] = v[0] ^ v[8] ^ v[16] ^ v[24] ^ v[32] ^ v[40] ^ v[48] ^ v[56];
            default: r = '0;
        endcase
        return r;
    endfunction

    // Issue one operation and check it in the following cycle.
    task automatic run_op(input string tag, input logic [3:0] o, input logic [63:0] v);
        @(negedge clk);
        in_valid = 1'b1; op = o; operand = v;
        @(negedge clk);
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check(tag, result, model(o, v));
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset result", result, 64'd0);
    endtask

    task automatic test_lead_word();
        run_op("R2 lzw zero", 4'd0, 64'd0);
        run_op("R2 lzw high ignored", 4'd0, 64'hFFFF_FFFF_0000_0000);
        run_op("R2 lzw bit31", 4'd0, 64'h0000_0000_8000_0000);
        run_op("R2 lzw bit0", 4'd0, 64'h0000_0000_0000_0001);
    endtask

    task automatic test_lead_dword();
        run_op("R3 lzd zero", 4'd1, 64'd0);
        run_op("R3 lzd bit63", 4'd1, 64'h8000_0000_0000_0000);
        run_op("R3 lzd bit32", 4'd1, 64'h0000_0001_0000_0000);
        run_op("R3 lzd bit0", 4'd1, 64'h1);
    endtask

    task automatic test_trail();
        run_op("R4 tzw zero", 4'd2, 64'd0);
        run_op("R4 tzw high ignored", 4'd2, 64'h0000_0001_0000_0000);
        run_op("R4 tzw bit31", 4'd2, 64'h0000_0000_8000_0000);
        run_op("R5 tzd zero", 4'd3, 64'd0);
        run_op("R5 tzd bit63", 4'd3, 64'h8000_0000_0000_0000);
        run_op("R5 tzd ones", 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic test_pop();
        run_op("R6 popb mix", 4'd4, 64'hFF7F_0301_F00F_8000);
        run_op("R6 popb ones", 4'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R7 popw mix", 4'd5, 64'hFFFF_FFFF_0000_0101);
        run_op("R7 popw ones", 4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R8 popd ones", 4'd6, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R8 popd mix", 4'd6, 64'h8000_0001_00F0_0003);
    endtask

    task automatic test_parity();
        run_op("R9 prtyw lsbs", 4'd7, 64'h0000_0001_0000_0101);
        run_op("R9 prtyw non-lsb", 4'd7, 64'hFEFE_FEFE_FEFE_FEFE);
        run_op("R9 prtyw all", 4'd7, 64'h0101_0101_0101_0001);
        run_op("R10 prtyd odd", 4'd8, 64'h0100_0000_0000_0000);
        run_op("R10 prtyd even", 4'd8, 64'h0101_0101_0101_0101);
        run_op("R10 prtyd non-lsb", 4'd8, 64'hFEFE_FEFE_FEFE_FEFE);
    endtask

    task automatic test_bad_op();
        run_op("R11 op9", 4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R11 op15", 4'd15, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic test_hold();
        run_op("R12 setup", 4'd6, 64'h0000_0000_0000_00FF);
        @(negedge clk);
        check("R1 idle valid low", 64'(out_valid), 64'd0);
        check("R12 held result", result, 64'd8);
        operand = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R12 held after operand change", result, 64'd8);
    endtask

    task automatic test_stream();
        @(negedge clk);
        in_valid = 1'b1; op = 4'd1; operand = 64'h0000_0000_0000_0100;
        @(negedge clk);
        check("R1 stream first", result, 64'd55);
        op = 4'd3; operand = 64'h0000_0000_0000_0100;
        @(negedge clk);
        check("R1 stream second valid", 64'(out_valid), 64'd1);
        check("R1 stream second", result, 64'd8);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 stream drain", 64'(out_valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_lead_word();
        test_lead_dword();
        test_trail();
        test_pop();
        test_parity();
        test_bad_op();
        test_hold();
        test_stream();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule